// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Slave

This block is a receive-only slave on a two-wire serial bus. It oversamples the clock and data lines with a fast system clock and watches for start and stop conditions. After a start it shifts in bytes, most significant bit first. The first byte must match the device address. The next two bytes are framing bytes: they are acknowledged and then dropped. The remaining bytes load a bank of configuration registers in order. The block acknowledges each accepted byte by pulling the data line low during the ninth clock. It never returns data on the bus.

Each register bit that has a function resets to its own default. The output-enable bits reset to 1 and the control byte resets to 0. Bits without a function are held at 0 whatever is written to them. The last two data bytes are received and have no effect. A transaction that ends early, through a stop or a repeated start, keeps every data byte that arrived complete and drops the partial byte. The host logic reads the register bank as one flat vector. In the control byte (byte 0), bit 3 selects whether frequency comes from strap inputs (0) or from the serial select field (1), bit 1 turns spreading on, and bit 0 forces the outputs to high impedance.

Top module: `cfg_twi_wo_slave`

## Requirements
- R1: On reset, `cfg_q` holds these values, with byte k at bits [8k+7:8k]: byte0=0x00, byte1=0x0F, byte2=0x7F, byte3=0x3F, byte4=0x00, byte5=0x33, byte6=0x00, byte7=0x00. `sda_pull_low` is 0.
- R2: A frame loads data bytes 0..7 into register bytes 0..7 in order, after the masking of R5. The frame is a start, the address byte 0xD2, a command byte, a count byte, then the data bytes. Each byte is taken most significant bit first.
- R3: When the address byte is not 0xD2 (including 0xD3), it is not acknowledged, no later byte is acknowledged until the next start, and no register changes.
- R4: The command and count bytes are acknowledged and their values do not affect the registers.
- R5: Only these bits can be written; every other bit is held at 0: byte0 0x7F, byte1 0x0F, byte2 0x7F, byte3 0x3F, byte5 0x33. Bytes 4, 6 and 7 always read 0.
- R6: For each accepted byte, `sda_pull_low` is 1 while SCL is high in the ninth clock and is 0 again shortly after the ninth falling edge. It never changes while SCL is high.
- R7: A stop before the frame is complete leaves the data bytes received so far in the registers and drops the partial byte.
- R8: A repeated start, whether between bytes or in the middle of one, begins a new frame at the address byte. Data bytes completed before it are kept.
- R9: A byte after the eleventh byte of a frame is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull_low | output | 1 | 1 pulls the data line low (acknowledge) |
| cfg_q | output | 64 | Register bank, byte k at bits [8k+7:8k] |

## Verification
The bench uses a data pattern that reads differently when bit-reversed, so a design that shifts least significant bit first loads wrong values. It sends wrong addresses, including the read form of the correct address. A slave that ignored the address would acknowledge these or change registers.

It writes all ones to catch reserved bits that are not forced to zero. It also cuts frames short with a stop or a repeated start in the middle of a byte. A design that committed partial bytes, or lost completed ones, would show different register contents. A twelfth byte checks that the slave stops acknowledging after the frame ends, instead of counting on.

// File: rtl/cfg_twi_pkg.sv
package cfg_twi_pkg;

  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_SHIFT  = 2'd1,
    RX_ACK    = 2'd2,
    RX_IGNORE = 2'd3
  } rx_state_e;

  // Value each register byte takes in reset.
  function automatic logic [7:0] cfg_reset_byte(input int unsigned idx);
    case (idx)
      1: return 8'h0F;
      2: return 8'h7F;
      3: return 8'h3F;
      5: return 8'h33;
      default: return 8'h00;
    endcase
  endfunction

  // Bits of each register byte that carry a function; others stay zero.
  function automatic logic [7:0] cfg_keep_mask(input int unsigned idx);
    case (idx)
      0: return 8'h7F;
      1: return 8'h0F;
      2: return 8'h7F;
      3: return 8'h3F;
      5: return 8'h33;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic scl_d,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] raw;
  logic [NUM_LINES-1:0] synced;
  logic                 sda_d;

  assign raw = {sda_in, scl_in};

  // Both bus lines take the same number of stages so their order is kept.
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[SYNC_STAGES-2:0], raw[l]};
    end
    assign synced[l] = chain[SYNC_STAGES-1];
  end

  assign scl_s = synced[0];
  assign sda_s = synced[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twi_wr_frame_rx.sv
module twi_wr_frame_rx
  import cfg_twi_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR  = 8'hD2,
  parameter int         NUM_SKIP  = 2,
  parameter int         NUM_REGS  = 8,
  localparam int        FIRST_DAT = 1 + NUM_SKIP,
  localparam int        TOTAL     = FIRST_DAT + NUM_REGS,
  localparam int        CNT_W     = $clog2(TOTAL + 1),
  localparam int        IDX_W     = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_pull_low,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);

  rx_state_e        state;
  logic [3:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0]       shreg;
  logic             byte_done;
  logic             addr_bad;
  logic             past_end;
  logic             is_data;

  assign byte_done = scl_fall && (bit_cnt == 4'd8);
  assign addr_bad  = (byte_cnt == '0) && (shreg != DEV_ADDR);
  assign past_end  = (byte_cnt == CNT_W'(TOTAL));
  assign is_data   = (byte_cnt >= CNT_W'(FIRST_DAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= RX_IDLE;
      bit_cnt      <= '0;
      byte_cnt     <= '0;
      shreg        <= '0;
      sda_pull_low <= 1'b0;
      wr_en        <= 1'b0;
      wr_idx       <= '0;
      wr_data      <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state        <= RX_SHIFT;
        bit_cnt      <= '0;
        byte_cnt     <= '0;
        sda_pull_low <= 1'b0;
      end else if (stop_det) begin
        state        <= RX_IDLE;
        sda_pull_low <= 1'b0;
      end else begin
        case (state)
          RX_SHIFT: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              if (past_end || addr_bad) begin
                state <= RX_IGNORE;
              end else begin
                state        <= RX_ACK;
                sda_pull_low <= 1'b1;
                if (is_data) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= IDX_W'(byte_cnt - CNT_W'(FIRST_DAT));
                  wr_data <= shreg;
                end
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              state        <= RX_SHIFT;
              sda_pull_low <= 1'b0;
              bit_cnt      <= '0;
              byte_cnt     <= byte_cnt + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_twi_pkg::*;
#(
  parameter int  NUM_REGS = 8,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] cfg_q
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RST_VAL = cfg_reset_byte(g);
    localparam logic [7:0] KEEP    = cfg_keep_mask(g);
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)                               q <= RST_VAL;
      else if (wr_en && wr_idx == IDX_W'(g)) q <= wr_data & KEEP;
    end
    assign cfg_q[g*8 +: 8] = q;
  end

endmodule

// File: rtl/cfg_twi_wo_slave.sv
module cfg_twi_wo_slave #(
  parameter logic [7:0] DEV_ADDR    = 8'hD2,
  parameter int         NUM_SKIP    = 2,
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDX_W       = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_pull_low,
  output logic [NUM_REGS*8-1:0] cfg_q
);

  logic             scl_s, scl_d, sda_s;
  logic             scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .scl_d     (scl_d),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_wr_frame_rx #(
    .DEV_ADDR (DEV_ADDR),
    .NUM_SKIP (NUM_SKIP),
    .NUM_REGS (NUM_REGS)
  ) rx_i (
    .clk          (clk),
    .rst          (rst),
    .sda_s        (sda_s),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .sda_pull_low (sda_pull_low),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS)) bank_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .cfg_q   (cfg_q)
  );

endmodule

// File: rtl/cfg_twi_wo_slave_chk.sv
module cfg_twi_wo_slave_chk
  import cfg_twi_pkg::*;
#(
  parameter int  NUM_REGS = 8,
  localparam int W        = NUM_REGS * 8
) (
  input logic         clk,
  input logic         rst,
  input logic         scl_s,
  input logic         scl_d,
  input logic         stop_det,
  input logic         wr_en,
  input logic         sda_pull_low,
  input logic [W-1:0] cfg_q
);

  logic [W-1:0] keep_v;
  logic [W-1:0] rst_v;
  logic         rst_d = 1'b0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_vec
    assign keep_v[g*8 +: 8] = cfg_keep_mask(g);
    assign rst_v[g*8 +: 8]  = cfg_reset_byte(g);
  end

  always_ff @(posedge clk) rst_d <= rst;

  // R1: one cycle into reset the bank shows its defaults
  always @(posedge clk) begin
    if (rst_d) begin
      p_reset_values_r1: assert (cfg_q == rst_v);
    end
  end

  // R3: registers move only after a write strobe from the receiver
  p_regs_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(cfg_q));

  // R5: bits without function stay zero
  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_q & ~keep_v) == '0);

  // R6: acknowledge drive is steady while SCL stays high
  p_ack_steady_r6: assert property (@(posedge clk) disable iff (rst)
    (scl_s && scl_d) |-> $stable(sda_pull_low));

  // R7: a stop releases the data line
  p_stop_release_r7: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull_low);

endmodule

bind cfg_twi_wo_slave cfg_twi_wo_slave_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .scl_s        (scl_s),
  .scl_d        (scl_d),
  .stop_det     (stop_det),
  .wr_en        (wr_en),
  .sda_pull_low (sda_pull_low),
  .cfg_q        (cfg_q)
);

// File: tb/cfg_twi_wo_slave_tb.sv
module cfg_twi_wo_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_bus;
  logic        sda_pull_low;
  logic [63:0] cfg_q;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;
  logic [7:0] exp_r [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull_low;

  cfg_twi_wo_slave dut_i (
    .clk          (clk),
    .rst          (rst),
    .scl_in       (scl_m),
    .sda_in       (sda_bus),
    .sda_pull_low (sda_pull_low),
    .cfg_q        (cfg_q)
  );

  function automatic logic [7:0] writable(input int i);
    case (i)
      0: return 8'h7F;
      1: return 8'h0F;
      2: return 8'h7F;
      3: return 8'h3F;
      5: return 8'h33;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [63:0] exp_vec();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = exp_r[i];
    return v;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(2*Q);
    sda_m = 1'b0; wait_clk(2*Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(2*Q);
    sda_m = 1'b1; wait_clk(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    wait_clk(Q);
    scl_m = 1'b1; wait_clk(2*Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  // Sends a byte and returns the ack level seen mid ninth clock and
  // the drive level just after the ninth falling edge.
  task automatic send_byte(input logic [7:0] b, output logic ack, output logic after);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    ack = sda_pull_low;
    wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
    after = sda_pull_low;
  endtask

  task automatic send_acked(input string req, input logic [7:0] b);
    logic a, r;
    send_byte(b, a, r);
    check({req, " ack"}, {63'd0, a}, 64'd1);
    check({req, " release"}, {63'd0, r}, 64'd0);
  endtask

  task automatic send_header(input string req, input logic [7:0] cmd, input logic [7:0] cnt);
    send_acked(req, 8'hD2);
    send_acked("R4 cmd", cmd);
    send_acked("R4 cnt", cnt);
  endtask

  task automatic load_exp(input int i, input logic [7:0] v);
    exp_r[i] = v & writable(i);
  endtask

  task automatic t_reset();
    check("R1 reset regs", cfg_q, 64'h0000_3300_3F7F_0F00);
    check("R1 reset ack", {63'd0, sda_pull_low}, 64'd0);
  endtask

  task automatic t_full_write(input logic [7:0] cmd, input logic [7:0] cnt,
                              input logic [63:0] pat);
    bus_start();
    send_header("R6 hdr", cmd, cnt);
    for (int i = 0; i < 8; i++) begin
      send_acked("R6 data", pat[i*8 +: 8]);
      load_exp(i, pat[i*8 +: 8]);
    end
    bus_stop();
    check("R2 R4 full write", cfg_q, exp_vec());
  endtask

  task automatic t_bad_addr(input logic [7:0] addr);
    logic a, r;
    logic any_ack;
    bus_start();
    send_byte(addr, a, r);
    check("R3 addr nack", {63'd0, a}, 64'd0);
    any_ack = 1'b0;
    for (int i = 0; i < 10; i++) begin
      send_byte(8'hFF, a, r);
      any_ack |= a;
    end
    bus_stop();
    check("R3 later nack", {63'd0, any_ack}, 64'd0);
    check("R3 regs kept", cfg_q, exp_vec());
  endtask

  task automatic t_reserved();
    bus_start();
    send_header("R5 hdr", 8'h00, 8'h08);
    for (int i = 0; i < 8; i++) begin
      send_acked("R5 data", 8'hFF);
      load_exp(i, 8'hFF);
    end
    bus_stop();
    check("R5 reserved zero", cfg_q, 64'h0000_3300_3F7F_0F7F);
  endtask

  task automatic t_early_stop();
    bus_start();
    send_header("R7 hdr", 8'h11, 8'h22);
    send_acked("R7 d0", 8'h0A); load_exp(0, 8'h0A);
    send_acked("R7 d1", 8'h05); load_exp(1, 8'h05);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    check("R7 early stop", cfg_q, exp_vec());
  endtask

  task automatic t_restart();
    logic a, r;
    bus_start();
    send_header("R8 hdr", 8'h33, 8'h44);
    send_acked("R8 d0", 8'h21); load_exp(0, 8'h21);
    send_acked("R8 d1", 8'h0C); load_exp(1, 8'h0C);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    send_byte(8'hD2, a, r);
    check("R8 addr after restart", {63'd0, a}, 64'd1);
    send_acked("R8 cmd", 8'h55);
    send_acked("R8 cnt", 8'h66);
    send_acked("R8 d0b", 8'h44); load_exp(0, 8'h44);
    bus_start();
    send_byte(8'hA4, a, r);
    check("R8 bad addr after restart", {63'd0, a}, 64'd0);
    send_byte(8'h7F, a, r);
    bus_stop();
    check("R8 restart regs", cfg_q, exp_vec());
  endtask

  task automatic t_extra_byte();
    logic a, r;
    bus_start();
    send_header("R9 hdr", 8'h99, 8'h01);
    for (int i = 0; i < 8; i++) begin
      send_acked("R9 data", 8'h00);
      load_exp(i, 8'h00);
    end
    send_byte(8'hFF, a, r);
    check("R9 extra nack", {63'd0, a}, 64'd0);
    bus_stop();
    check("R9 extra ignored", cfg_q, 64'd0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_r[i] = 8'h00;
    exp_r[1] = 8'h0F; exp_r[2] = 8'h7F; exp_r[3] = 8'h3F; exp_r[5] = 8'h33;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_full_write(8'hA5, 8'h3C, 64'h96_81_C3_FF_E7_F0_24_1B);
    t_full_write(8'h00, 8'hFF, 64'h11_22_21_00_16_35_4A_62);
    t_bad_addr(8'hD0);
    t_bad_addr(8'hD3);
    t_reserved();
    t_early_stop();
    t_restart();
    t_extra_byte();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule